// File: doc/BRIEF.md
# Loadable Synchronous Binary Counter with Cascade

This block is a synchronous binary up-counter built from four-bit stages. Every state change happens on the rising clock edge: an active-low clear forces the count to zero, an active-low load copies a parallel data word into the count, and otherwise the count advances by one only while two separate enable inputs are both high. A terminal-count flag goes high while the count is all ones and the second enable is high, so a following stage can use it as its own second enable.

A parameter sets how many four-bit stages are chained (one or two). With two stages the low stage's flag drives the high stage's second enable, which gives an eight-bit counter whose flag marks 0xFF. A second parameter turns on offset mode. In this mode the terminal-count flag also acts as a load, so after the all-ones state the counter reloads the data word instead of wrapping to zero, and it counts upward from that programmable start value.

Top module: `loadable_cascade_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, the whole count is 0 after that edge, whatever `ld_n`, `din`, `en_p` and `en_t` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, the count equals `din` after that edge, even with both enables low.
- R3: When `clr_n` and `ld_n` are 1 and `en_p` or `en_t` is 0, the count does not change at the edge. In offset mode a terminal-count reload is the only exception (see R7).
- R4: When `clr_n`, `ld_n`, `en_p` and `en_t` are all 1 and no offset reload applies, the count goes up by one, modulo 2^(4·STAGES).
- R5: `carry_out` is 1 in the same cycle, with no register delay, exactly when `en_t` is 1 and every bit of `q` is 1.
- R6: With two stages, bits 7:4 advance only on an edge where bits 3:0 are 1111 and both enables are 1. An 8-bit count goes 0xFE, 0xFF, 0x00, and `carry_out` is 1 only at 0xFF.
- R7: With offset mode on, an edge where `carry_out` is 1 (and `clr_n` is 1) loads `din`. With `din` = 0110 the sequence is 0110, 0111, …, 1111, 0110. This reload happens even when `en_p` is 0.
- R8: Priority at an edge is clear, then load, then count. Clear together with load gives 0, and load together with count enabled gives `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4·STAGES | Parallel load data (offset start value in offset mode) |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | 4·STAGES | Present count |
| carry_out | output | 1 | Terminal-count flag: `en_t` high and count all ones |

## Verification
Each stage holds its whole state in `q`, so a wrong register value shows at the port on the cycle after the faulty edge. A broken carry chain is less visible. It only shows when the low nibble reaches 1111, so the bench runs the eight-bit count through the 0x?F boundaries and through the 0xFF to 0x00 wrap. It also holds `en_t` low at 0x3F to catch a high stage that advances when it should not. Offset mode fails only at the all-ones state, so the bench reaches that state several times, including once with `en_p` low.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

   localparam int unsigned STAGE_BITS = 4;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } lcc_op_e;

endpackage

// File: rtl/lcc_op_decode.sv
module lcc_op_decode
   import lcc_pkg::*;
(
   input  logic    clr_n,
   input  logic    ld_n,
   input  logic    en_p,
   input  logic    en_t,
   output lcc_op_e op
);

   always_comb begin
      if (!clr_n)
         op = OP_CLEAR;
      else if (!ld_n)
         op = OP_LOAD;
      else if (en_p && en_t)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/lcc_carry_detect.sv
module lcc_carry_detect #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             en_t,
   output logic             rco
);

   assign rco = en_t && (&q);

endmodule

// File: rtl/lcc_stage.sv
module lcc_stage
   import lcc_pkg::*;
#(
   parameter int unsigned WIDTH = STAGE_BITS
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             ld_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             rco
);

   lcc_op_e op;

   lcc_op_decode u_dec (
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (en_t),
      .op    (op)
   );

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q <= '0;
         OP_LOAD:  q <= d;
         OP_COUNT: q <= q + WIDTH'(1);
         default:  q <= q;
      endcase
   end

   lcc_carry_detect #(.WIDTH(WIDTH)) u_rco (
      .q    (q),
      .en_t (en_t),
      .rco  (rco)
   );

endmodule

// File: rtl/loadable_cascade_counter.sv
module loadable_cascade_counter
   import lcc_pkg::*;
#(
   parameter int unsigned WIDTH       = STAGE_BITS,
   parameter int unsigned STAGES      = 2,
   parameter bit          OFFSET_LOAD = 1'b0,
   localparam int unsigned TOTAL      = WIDTH * STAGES
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             ld_n,
   input  logic [TOTAL-1:0] din,
   input  logic             en_p,
   input  logic             en_t,
   output logic [TOTAL-1:0] q,
   output logic             carry_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("loadable_cascade_counter: WIDTH must be at least 1");
   end
   if (STAGES < 1 || STAGES > 2) begin : g_bad_stages
      $error("loadable_cascade_counter: STAGES must be 1 or 2");
   end

   logic [STAGES:0] t_chain;
   logic            ld_eff_n;

   assign t_chain[0] = en_t;
   assign carry_out  = t_chain[STAGES];

   if (OFFSET_LOAD) begin : g_offset
      assign ld_eff_n = ld_n && !carry_out;
   end else begin : g_plain
      assign ld_eff_n = ld_n;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      lcc_stage #(.WIDTH(WIDTH)) u_stage (
         .clk   (clk),
         .clr_n (clr_n),
         .ld_n  (ld_eff_n),
         .en_p  (en_p),
         .en_t  (t_chain[s]),
         .d     (din[s*WIDTH +: WIDTH]),
         .q     (q[s*WIDTH +: WIDTH]),
         .rco   (t_chain[s+1])
      );
   end

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
   parameter int unsigned WIDTH       = 4,
   parameter int unsigned STAGES      = 2,
   parameter bit          OFFSET_LOAD = 1'b0,
   localparam int unsigned TOTAL      = WIDTH * STAGES
) (
   input logic             clk,
   input logic             clr_n,
   input logic             ld_n,
   input logic [TOTAL-1:0] din,
   input logic             en_p,
   input logic             en_t,
   input logic [TOTAL-1:0] q,
   input logic             carry_out
);

   logic armed = 1'b0;
   always_ff @(posedge clk)
      if (!clr_n) armed <= 1'b1;

   p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> (q == '0));

   p_load_r2: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !ld_n) |=> (q == $past(din)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && ld_n && !(en_p && en_t) && !(OFFSET_LOAD && carry_out))
      |=> $stable(q));

   p_count_r4: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && ld_n && en_p && en_t && !(OFFSET_LOAD && carry_out))
      |=> (q == $past(q) + TOTAL'(1)));

   p_carry_set_r5: assert property (@(posedge clk) disable iff (!armed)
      (en_t && (&q)) |-> carry_out);

   p_carry_clr_r5: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> (en_t && (&q)));

   p_offset_r7: assert property (@(posedge clk) disable iff (!armed)
      (OFFSET_LOAD && clr_n && carry_out) |=> (q == $past(din)));

endmodule

bind loadable_cascade_counter lcc_checker #(
   .WIDTH       (WIDTH),
   .STAGES      (STAGES),
   .OFFSET_LOAD (OFFSET_LOAD)
) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .ld_n      (ld_n),
   .din       (din),
   .en_p      (en_p),
   .en_t      (en_t),
   .q         (q),
   .carry_out (carry_out)
);

// File: tb/tb_loadable_cascade_counter.sv
`timescale 1ns/1ps
module tb_loadable_cascade_counter;

   logic       clk = 1'b0;
   logic       clr_n, ld_n, en_p, en_t;
   logic [7:0] din;
   logic [7:0] q8;
   logic [3:0] q4;
   logic       co8, co4;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   int m8 = 0;
   int m4 = 0;

   always #10 clk = ~clk;

   loadable_cascade_counter #(.WIDTH(4), .STAGES(2), .OFFSET_LOAD(1'b0)) dut (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
      .en_p(en_p), .en_t(en_t), .q(q8), .carry_out(co8));

   loadable_cascade_counter #(.WIDTH(4), .STAGES(1), .OFFSET_LOAD(1'b1)) dut_ofs (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din[3:0]),
      .en_p(en_p), .en_t(en_t), .q(q4), .carry_out(co4));

   // behavioural reference: plain integers, updated on each rising edge
   always @(posedge clk) begin
      int n8, n4;
      if (!clr_n)               n8 = 0;
      else if (!ld_n)           n8 = din;
      else if (en_p && en_t)    n8 = (m8 + 1) % 256;
      else                      n8 = m8;
      if (!clr_n)                      n4 = 0;
      else if (!ld_n || (en_t && m4 == 15)) n4 = din[3:0];
      else if (en_p && en_t)           n4 = (m4 + 1) % 16;
      else                             n4 = m4;
      m8 = n8;
      m4 = n4;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      check(req, "q8", int'(q8), m8);
      check("R5", "carry8", int'(co8), int'(en_t && m8 == 255));
      check(req == "R6" ? "R7" : req, "q4", int'(q4), m4);
      check("R5", "carry4", int'(co4), int'(en_t && m4 == 15));
   endtask

   // drive inputs after a falling edge, compare after the next falling edge
   task automatic cyc(input string req, input bit c, input bit l, input bit p,
                      input bit t, input logic [7:0] d);
      clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
      @(negedge clk);
      compare_all(req);
   endtask

   initial begin
      clr_n = 1'b0; ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1; din = 8'h5A;
      @(negedge clk);
      // R1: reset state from clear, enables high
      cyc("R1", 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
      check("R1", "q8 reset", int'(q8), 0);
      check("R1", "q4 reset", int'(q4), 0);
      // R4: plain counting across low-nibble carries
      for (int i = 0; i < 20; i++) cyc("R4", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      // R3: each enable low alone holds
      for (int i = 0; i < 4; i++) cyc("R3", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
      for (int i = 0; i < 4; i++) cyc("R3", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      // R2: load with both enables low
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3);
      check("R2", "q8 loaded", int'(q8), 8'hC3);
      // R8: clear beats load, load beats count
      cyc("R8", 1'b0, 1'b0, 1'b1, 1'b1, 8'h77);
      check("R8", "clear over load", int'(q8), 0);
      cyc("R8", 1'b1, 1'b0, 1'b1, 1'b1, 8'h91);
      check("R8", "load over count", int'(q8), 8'h91);
      // R6 / R7: 8-bit wrap and offset reload from 0110
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'hF6);
      for (int i = 0; i < 30; i++) begin
         cyc("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'hF6);
         if (i == 8) begin
            check("R6", "q8 at FF", int'(q8), 8'hFF);
            check("R6", "carry at FF", int'(co8), 1);
            check("R7", "q4 at 1111", int'(q4), 15);
         end
         if (i == 9) begin
            check("R6", "q8 wrap", int'(q8), 0);
            check("R7", "q4 offset reload", int'(q4), 6);
         end
      end
      // R6: en_t low at 0x3F must not advance the high stage
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3F);
      for (int i = 0; i < 3; i++) cyc("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'h36);
      check("R6", "high stage hold", int'(q8), 8'h3F);
      // R7: reload with en_p low
      cyc("R7", 1'b1, 1'b1, 1'b0, 1'b1, 8'h36);
      check("R7", "reload with en_p low", int'(q4), 6);
      check("R3", "q8 held en_p low", int'(q8), 8'h3F);
      // mixed patterns
      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom % 100;
         cyc("R8", !(r < 3), !(r >= 3 && r < 8), ($urandom % 8) != 0,
             ($urandom % 8) != 0, 8'($urandom));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule